// File: doc/BRIEF.md
# Delay-Slot Program Counter Sequencer

This block holds the program-counter state of a fixed-length instruction pipeline that has one branch delay slot and steps through several micro-operations inside each instruction. It keeps three addresses: the instruction now executing, the one in the delay slot and the one after that. It also keeps two micro-operation indices, the current one and the next one. All five values are registered and visible at the outputs.

Each cycle the surrounding control logic issues at most one effective command. Several commands may be raised in the same cycle, and a fixed priority picks the one that takes effect. A load restarts the sequence at a new address. An end-of-instruction command shifts the address chain by one place and restarts the micro-op count. A micro-step moves the micro-op pair forward and leaves the addresses alone. Branch logic can write the delay-slot address and the one after it directly. A combinational flag reports whenever the held state has left straight-line flow.

Top module: `pcseq_delay_slot`

## Requirements
- R1: A load of address A sets the current address to A, the delay-slot address to A+S and the third address to A+2S on the next clock edge. S is the instruction size in bytes and defaults to 4.
- R2: A load sets the current micro index to 0 and the next micro index to 1.
- R3: End-of-instruction moves the delay-slot address into the current address and the third address into the delay-slot address. It sets the third address to its old value plus S. In the same edge it sets the micro indices to 0 and 1.
- R4: A micro-step copies the next micro index into the current one and increments the next micro index by one. All three addresses keep their values.
- R5: When no load, end or step is active, the two write enables each replace the delay-slot address or the third address with their own data. The two enables act independently and may act together.
- R6: The address part counts as sequential only when the third address equals the delay-slot address plus S, and the delay-slot address equals the current address plus S or plus 2S.
- R7: `branching_o` is 1 when the address part is not sequential or when the next micro index differs from the current micro index plus one. It is a combinational function of the held registers.
- R8: Synchronous active-high reset clears all five registers to zero, so `branching_o` reads 1 after reset.
- R9: Priority among simultaneous commands is load, then end-of-instruction, then micro-step, then the direct writes. A command that loses has no effect at all.
- R10: All address arithmetic wraps modulo 2^AW, and micro index arithmetic wraps modulo 2^UW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Restart the sequence at `load_addr_i` |
| load_addr_i | input | AW | Restart address |
| iend_i | input | 1 | End of the current instruction |
| ustep_i | input | 1 | Advance to the next micro-operation |
| npc_we_i | input | 1 | Write the delay-slot address |
| npc_wdata_i | input | AW | Data for the delay-slot address |
| nnpc_we_i | input | 1 | Write the third address |
| nnpc_wdata_i | input | AW | Data for the third address |
| pc_o | output | AW | Current instruction address |
| npc_o | output | AW | Delay-slot address |
| nnpc_o | output | AW | Address after the delay slot |
| upc_o | output | UW | Current micro-op index |
| nupc_o | output | UW | Next micro-op index |
| branching_o | output | 1 | State deviates from sequential flow |

## Verification
The functions that collide are the command strobes. Load, end-of-instruction, micro-step and the direct writes can all be raised in one cycle, and only the winner may touch the state. The vector table raises two or three of them together: a step with a delay-slot write, an end with a step and a third-address write, and a load with an end and a step. It then compares all five registers with the values that only the winning command produces. This also shows that the losing writes left nothing behind. A second collision is a delay-slot write and a third-address write in the same cycle. The bench judges that case by both values landing and by the flag staying low for the plus-2S delay-slot pattern.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    localparam int DEF_INST_BYTES = 4;
    localparam int DEF_AW         = 32;
    localparam int DEF_UW         = 16;

    // The single command that takes effect in a cycle.
    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_LOAD = 3'd1,
        CMD_END  = 3'd2,
        CMD_STEP = 3'd3,
        CMD_OVWR = 3'd4
    } pcseq_cmd_e;

    // Decoded request bundle produced by the arbiter.
    typedef struct packed {
        pcseq_cmd_e cmd;
        logic       wr_npc;
        logic       wr_nnpc;
    } pcseq_req_t;

endpackage

// File: rtl/pcseq_arbiter.sv
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       iend_i,
    input  logic       ustep_i,
    input  logic       npc_we_i,
    input  logic       nnpc_we_i,
    output pcseq_req_t req_o
);

    always_comb begin
        req_o = '{cmd: CMD_IDLE, wr_npc: 1'b0, wr_nnpc: 1'b0};
        if (load_i) begin
            req_o.cmd = CMD_LOAD;
        end else if (iend_i) begin
            req_o.cmd = CMD_END;
        end else if (ustep_i) begin
            req_o.cmd = CMD_STEP;
        end else if (npc_we_i || nnpc_we_i) begin
            req_o.cmd     = CMD_OVWR;
            req_o.wr_npc  = npc_we_i;
            req_o.wr_nnpc = nnpc_we_i;
        end
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_i |-> req_o.cmd == CMD_LOAD); // R9

    AST_WRITES_LOSE: assert property (@(posedge clk) disable iff (rst)
        (load_i || iend_i || ustep_i) |-> !(req_o.wr_npc || req_o.wr_nnpc)); // R9

endmodule

// File: rtl/pcseq_addr_chain.sv
module pcseq_addr_chain
    import pcseq_pkg::*;
#(
    parameter int INST_BYTES = DEF_INST_BYTES,
    parameter int AW         = DEF_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  pcseq_req_t    req_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic [AW-1:0] npc_wdata_i,
    input  logic [AW-1:0] nnpc_wdata_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] npc_o,
    output logic [AW-1:0] nnpc_o
);

    localparam logic [AW-1:0] STRIDE  = AW'(INST_BYTES);
    localparam logic [AW-1:0] STRIDE2 = AW'(2 * INST_BYTES);

    typedef struct packed {
        logic [AW-1:0] cur;
        logic [AW-1:0] nxt;
        logic [AW-1:0] nnx;
    } chain_t;

    chain_t q, d;

    always_comb begin
        d = q;
        unique case (req_i.cmd)
            CMD_LOAD: begin
                d.cur = load_addr_i;
                d.nxt = load_addr_i + STRIDE;
                d.nnx = load_addr_i + STRIDE2;
            end
            CMD_END: begin
                d.cur = q.nxt;
                d.nxt = q.nnx;
                d.nnx = q.nnx + STRIDE;
            end
            CMD_OVWR: begin
                if (req_i.wr_npc)  d.nxt = npc_wdata_i;
                if (req_i.wr_nnpc) d.nnx = nnpc_wdata_i;
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign pc_o   = q.cur;
    assign npc_o  = q.nxt;
    assign nnpc_o = q.nnx;

    AST_LOAD_FILL: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_LOAD) |=> (pc_o == $past(load_addr_i)
            && npc_o == $past(load_addr_i) + STRIDE
            && nnpc_o == $past(load_addr_i) + STRIDE2)); // R1

    AST_END_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_END) |=> (pc_o == $past(npc_o)
            && npc_o == $past(nnpc_o)
            && nnpc_o == $past(nnpc_o) + STRIDE)); // R3

    AST_STEP_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_STEP) |=> ($stable(pc_o) && $stable(npc_o) && $stable(nnpc_o))); // R4

    AST_OVWR_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_OVWR) |=> $stable(pc_o)); // R5

endmodule

// File: rtl/pcseq_micro.sv
module pcseq_micro
    import pcseq_pkg::*;
#(
    parameter int UW = DEF_UW
) (
    input  logic          clk,
    input  logic          rst,
    input  pcseq_req_t    req_i,
    output logic [UW-1:0] upc_o,
    output logic [UW-1:0] nupc_o
);

    localparam logic [UW-1:0] ONE = UW'(1);

    typedef struct packed {
        logic [UW-1:0] cur;
        logic [UW-1:0] nxt;
    } upair_t;

    upair_t q, d;

    always_comb begin
        d = q;
        unique case (req_i.cmd)
            CMD_LOAD, CMD_END: begin
                d.cur = '0;
                d.nxt = ONE;
            end
            CMD_STEP: begin
                d.cur = q.nxt;
                d.nxt = q.nxt + ONE;
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign upc_o  = q.cur;
    assign nupc_o = q.nxt;

    AST_USTEP_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_STEP) |=> (upc_o == $past(nupc_o) && nupc_o == $past(nupc_o) + ONE)); // R4

    AST_UEND_RESTART: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_END) |=> (upc_o == '0 && nupc_o == ONE)); // R3

    AST_ULOAD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (req_i.cmd == CMD_LOAD) |=> (upc_o == '0 && nupc_o == ONE)); // R2

endmodule

// File: rtl/pcseq_branch_detect.sv
module pcseq_branch_detect #(
    parameter int INST_BYTES = 4,
    parameter int AW         = 32,
    parameter int UW         = 16
) (
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] npc_i,
    input  logic [AW-1:0] nnpc_i,
    input  logic [UW-1:0] upc_i,
    input  logic [UW-1:0] nupc_i,
    output logic          branching_o
);

    localparam logic [AW-1:0] STRIDE  = AW'(INST_BYTES);
    localparam logic [AW-1:0] STRIDE2 = AW'(2 * INST_BYTES);

    logic tail_seq, head_seq, addr_seq, micro_seq;

    always_comb begin
        tail_seq    = (nnpc_i == npc_i + STRIDE);
        head_seq    = (npc_i == pc_i + STRIDE) || (npc_i == pc_i + STRIDE2);
        addr_seq    = tail_seq && head_seq;
        micro_seq   = (nupc_i == upc_i + UW'(1));
        branching_o = !(addr_seq && micro_seq);
    end

endmodule

// File: rtl/pcseq_delay_slot.sv
module pcseq_delay_slot
    import pcseq_pkg::*;
#(
    parameter int INST_BYTES = DEF_INST_BYTES,
    parameter int AW         = DEF_AW,
    parameter int UW         = DEF_UW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic          iend_i,
    input  logic          ustep_i,
    input  logic          npc_we_i,
    input  logic [AW-1:0] npc_wdata_i,
    input  logic          nnpc_we_i,
    input  logic [AW-1:0] nnpc_wdata_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] npc_o,
    output logic [AW-1:0] nnpc_o,
    output logic [UW-1:0] upc_o,
    output logic [UW-1:0] nupc_o,
    output logic          branching_o
);

    pcseq_req_t req;

    pcseq_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .iend_i    (iend_i),
        .ustep_i   (ustep_i),
        .npc_we_i  (npc_we_i),
        .nnpc_we_i (nnpc_we_i),
        .req_o     (req)
    );

    pcseq_addr_chain #(.INST_BYTES(INST_BYTES), .AW(AW)) u_chain (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .load_addr_i  (load_addr_i),
        .npc_wdata_i  (npc_wdata_i),
        .nnpc_wdata_i (nnpc_wdata_i),
        .pc_o         (pc_o),
        .npc_o        (npc_o),
        .nnpc_o       (nnpc_o)
    );

    pcseq_micro #(.UW(UW)) u_micro (
        .clk    (clk),
        .rst    (rst),
        .req_i  (req),
        .upc_o  (upc_o),
        .nupc_o (nupc_o)
    );

    pcseq_branch_detect #(.INST_BYTES(INST_BYTES), .AW(AW), .UW(UW)) u_brdet (
        .pc_i        (pc_o),
        .npc_i       (npc_o),
        .nnpc_i      (nnpc_o),
        .upc_i       (upc_o),
        .nupc_i      (nupc_o),
        .branching_o (branching_o)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && npc_o == '0 && nnpc_o == '0 && upc_o == '0 && nupc_o == '0)); // R8

    AST_LOAD_NOT_BRANCHING: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !branching_o); // R7

endmodule

// File: tb/pcseq_delay_slot_bench.sv
module pcseq_delay_slot_bench;

    localparam int AW = 32;
    localparam int UW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_i, iend_i, ustep_i, npc_we_i, nnpc_we_i;
    logic [AW-1:0] load_addr_i, npc_wdata_i, nnpc_wdata_i;
    logic [AW-1:0] pc_o, npc_o, nnpc_o;
    logic [UW-1:0] upc_o, nupc_o;
    logic          branching_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    pcseq_delay_slot u_pcseq_delay_slot (
        .clk(clk), .rst(rst),
        .load_i(load_i), .load_addr_i(load_addr_i),
        .iend_i(iend_i), .ustep_i(ustep_i),
        .npc_we_i(npc_we_i), .npc_wdata_i(npc_wdata_i),
        .nnpc_we_i(nnpc_we_i), .nnpc_wdata_i(nnpc_wdata_i),
        .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
        .upc_o(upc_o), .nupc_o(nupc_o), .branching_o(branching_o)
    );

    typedef struct packed {
        logic [31:0]   tag;
        logic          ld;
        logic [AW-1:0] adr;
        logic          wn;
        logic [AW-1:0] wnd;
        logic          wnn;
        logic [AW-1:0] wnnd;
        logic          st;
        logic          en;
        logic [AW-1:0] e_pc;
        logic [AW-1:0] e_npc;
        logic [AW-1:0] e_nnpc;
        logic [UW-1:0] e_upc;
        logic [UW-1:0] e_nupc;
        logic          e_br;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        // R1 R2: load 0x100
        '{"R1  ",1'b1,32'h100,1'b0,32'h0,1'b0,32'h0,1'b0,1'b0,32'h100,32'h104,32'h108,16'd0,16'd1,1'b0},
        // R4: two micro-steps
        '{"R4  ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b1,1'b0,32'h100,32'h104,32'h108,16'd1,16'd2,1'b0},
        '{"R4  ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b1,1'b0,32'h100,32'h104,32'h108,16'd2,16'd3,1'b0},
        // R3: end of instruction
        '{"R3  ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'h104,32'h108,32'h10C,16'd0,16'd1,1'b0},
        // R5 R6: third address taken to 0x200
        '{"R5  ",1'b0,32'h0,1'b0,32'h0,1'b1,32'h200,1'b0,1'b0,32'h104,32'h108,32'h200,16'd0,16'd1,1'b1},
        // R6: delay slot now points off-sequence
        '{"R6  ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'h108,32'h200,32'h204,16'd0,16'd1,1'b1},
        '{"R6  ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'h200,32'h204,32'h208,16'd0,16'd1,1'b0},
        // R5 R6: both writes, delay slot at +2S is sequential
        '{"R5  ",1'b0,32'h0,1'b1,32'h208,1'b1,32'h20C,1'b0,1'b0,32'h200,32'h208,32'h20C,16'd0,16'd1,1'b0},
        // R9: step beats a delay-slot write
        '{"R9  ",1'b0,32'h0,1'b1,32'h400,1'b0,32'h0,1'b1,1'b0,32'h200,32'h208,32'h20C,16'd1,16'd2,1'b0},
        // R9: end beats step and third-address write
        '{"R9  ",1'b0,32'h0,1'b0,32'h0,1'b1,32'h500,1'b1,1'b1,32'h208,32'h20C,32'h210,16'd0,16'd1,1'b0},
        // R9: load beats end and step
        '{"R9  ",1'b1,32'h300,1'b0,32'h0,1'b0,32'h0,1'b1,1'b1,32'h300,32'h304,32'h308,16'd0,16'd1,1'b0},
        // R10: load near the top of the address space
        '{"R10 ",1'b1,32'hFFFFFFF8,1'b0,32'h0,1'b0,32'h0,1'b0,1'b0,32'hFFFFFFF8,32'hFFFFFFFC,32'h0,16'd0,16'd1,1'b0},
        '{"R10 ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b1,32'hFFFFFFFC,32'h0,32'h4,16'd0,16'd1,1'b0},
        // idle holds state
        '{"R9  ",1'b0,32'h0,1'b0,32'h0,1'b0,32'h0,1'b0,1'b0,32'hFFFFFFFC,32'h0,32'h4,16'd0,16'd1,1'b0}
    };

    task automatic drive_idle();
        load_i = 1'b0; iend_i = 1'b0; ustep_i = 1'b0;
        npc_we_i = 1'b0; nnpc_we_i = 1'b0;
        load_addr_i = '0; npc_wdata_i = '0; nnpc_wdata_i = '0;
    endtask

    task automatic check_state(input string req, input logic [AW-1:0] pc_e, npc_e, nnpc_e,
                               input logic [UW-1:0] upc_e, nupc_e, input logic br_e);
        n_checks++;
        if (pc_o !== pc_e || npc_o !== npc_e || nnpc_o !== nnpc_e ||
            upc_o !== upc_e || nupc_o !== nupc_e || branching_o !== br_e) begin
            n_fails++;
            $display("FAIL %s: got pc=%h npc=%h nnpc=%h upc=%0d nupc=%0d br=%b, expected pc=%h npc=%h nnpc=%h upc=%0d nupc=%0d br=%b",
                     req, pc_o, npc_o, nnpc_o, upc_o, nupc_o, branching_o,
                     pc_e, npc_e, nnpc_e, upc_e, nupc_e, br_e);
        end
    endtask

    initial begin
        for (int c = 0; c < 5000; c++) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive_idle();
        for (int i = 0; i < 3; i++) @(posedge clk);
        @(negedge clk);
        // R8: reset clears everything; R7: flag high
        check_state("R8", '0, '0, '0, '0, '0, 1'b1);
        rst = 1'b0;

        // R4 R7: step from reset state fixes the micro pair, addresses still off
        ustep_i = 1'b1;
        @(negedge clk);
        check_state("R4", '0, '0, '0, 16'd0, 16'd1, 1'b1);

        for (int v = 0; v < NV; v++) begin
            load_i = VEC[v].ld;       load_addr_i  = VEC[v].adr;
            npc_we_i = VEC[v].wn;     npc_wdata_i  = VEC[v].wnd;
            nnpc_we_i = VEC[v].wnn;   nnpc_wdata_i = VEC[v].wnnd;
            ustep_i = VEC[v].st;      iend_i = VEC[v].en;
            @(negedge clk);
            check_state($sformatf("%s", VEC[v].tag), VEC[v].e_pc, VEC[v].e_npc, VEC[v].e_nnpc,
                        VEC[v].e_upc, VEC[v].e_nupc, VEC[v].e_br);
        end

        // R7: after a load, a step in the micro index stays sequential
        drive_idle();
        load_i = 1'b1; load_addr_i = 32'h40;
        @(negedge clk);
        drive_idle();
        ustep_i = 1'b1;
        @(negedge clk);
        check_state("R7", 32'h40, 32'h44, 32'h48, 16'd1, 16'd2, 1'b0);

        // R8: mid-run reset with commands pending
        iend_i = 1'b1; rst = 1'b1;
        @(negedge clk);
        check_state("R8", '0, '0, '0, '0, '0, 1'b1);
        rst = 1'b0;
        drive_idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule